// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control side of a 10-bit successive-approximation A/D converter inside a small microcontroller. Software drives a start bit, a 3-bit pin-configuration field, a 2-bit clock-select field, a 2-bit channel-select field, an interrupt enable and an interrupt clear. The block reports a busy flag, a result word and an interrupt request. The pin-configuration field is decoded into one analog-enable line per channel pin and one converter power-enable line. During a conversion the block drives a trial code and a channel number to an external DAC and comparator, and it reads the comparator decision back one bit per conversion clock.

A conversion needs a full pulse of the start bit: first high, then low. While the start bit is held high, the converter stays in reset and the busy flag reads 1. A rising start bit during a running conversion aborts it. The controller has four states:
- `ST_IDLE`: waiting.
- `ST_HOLD`: start bit high, converter held in reset.
- `ST_CONV`: bits being resolved.
- `ST_DONE`: one cycle after the last bit.

The transitions are:
- any state → `ST_HOLD` when the start bit is sampled high.
- `ST_HOLD` → `ST_CONV` when it is sampled low, which is the release.
- `ST_CONV` → `ST_DONE` on the conversion-clock tick that resolves bit 0.
- `ST_DONE` → `ST_IDLE` unconditionally.

Software can either wait for the interrupt or poll the busy flag until it reads 0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Holding the start bit low from `ST_IDLE` starts nothing: the busy flag, the result, the interrupt flag and the trial code keep their values.
- R2: While the start bit is high, the busy flag reads 1 and the trial code reads 0. A conversion in progress is abandoned with no result update and no interrupt.
- R3: After a high-then-low start pulse, the busy flag falls exactly 10×ratio system clock cycles after the clock edge that first samples the start bit low. After that it stays 0 until the next time the start bit goes high.
- R4: The interrupt flag is set on the edge at which the busy flag falls and is not set at any other time. It stays set until `irq_clr` is sampled high. If completion and `irq_clr` fall on the same edge, the set takes priority.
- R5: `irq_out` is 1 exactly when the interrupt flag and `int_en` are both 1.
- R6: The pin-configuration field is decoded as follows:
  - 000: no analog pins, and `pwr_en` is 0.
  - 001: analog on channel 0 only.
  - 010: analog on channels 0 and 1.
  - 011: analog on channels 0 to 2.
  - 100 or above: all four channels are analog.
  - `pwr_en` is 1 for every nonzero value. Bit i of `ana_en` is channel i.
- R7: The clock-select field sets the ratio as follows: 00 divides by 2, 01 by 8, and 10 and 11 both by 32. The value is sampled on the edge at which the conversion begins, and later changes do not affect that conversion.
- R8: Bits are resolved MSB first, one per conversion clock. A trial bit is kept when `cmp_in` is 1, meaning the analog input is at or above `dac_code`. The result is therefore the largest code that the comparator accepts.
- R9: `result` changes only on the edge at which the busy flag falls.
- R10: The channel-select field is sampled when the conversion begins and is driven on `dac_chan` for the whole conversion.
- R11: After reset, the outputs are as follows:
  - busy flag: 1
  - interrupt flag: 0
  - `result`: 0
  - `dac_code`: 0
  - `dac_chan`: 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_bit | input | 1 | Software start/reset control bit |
| int_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt request flag |
| pin_cfg | input | 3 | Pin-configuration field |
| clk_sel | input | 2 | Conversion clock divider select |
| chan_sel | input | 2 | Analog channel select |
| cmp_in | input | 1 | Comparator decision from the analog side |
| busy | output | 1 | End-of-conversion flag, 1 while not finished |
| irq_flag | output | 1 | Conversion-complete request flag |
| irq_out | output | 1 | Gated interrupt to the controller |
| result | output | 10 | Latched conversion result |
| dac_code | output | 10 | Trial code for the DAC |
| dac_chan | output | 2 | Channel routed to the comparator |
| ana_en | output | 4 | Per-pin analog enable |
| pwr_en | output | 1 | Converter power enable |

## Verification
Two events can fall on the same clock edge: the completion of a conversion, which sets the request flag, and a software clear of that flag. The bench holds `irq_clr` high for an entire conversion so that the clear is present on the completion edge. It expects the flag to read 1 just after that edge and to read 0 one edge later. A second collision is a start-bit rise during a running conversion, where the abort must win over any further bit decision. This is judged by the trial code returning to 0, the result staying unchanged and no request being raised.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CONV = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
// Conversion clock enable: one tick every N system cycles while running.
// The ratio is captured continuously while idle and frozen once run rises.
module adc_clk_div #(
    parameter int DIV_A = 2,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAX_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_DIV = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
    localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] sel_limit;

    always_comb begin
        unique case (sel)
            2'b00:   sel_limit = CNT_W'(DIV_A - 1);
            2'b01:   sel_limit = CNT_W'(DIV_B - 1);
            default: sel_limit = CNT_W'(DIV_C - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (!run) begin
            cnt_q   <= '0;
            limit_q <= sel_limit;
        end else if (cnt_q == limit_q) begin
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == limit_q);

endmodule

// File: rtl/adc_pin_map.sv
`timescale 1ns/1ps
// Pin-configuration decode: channel i is analog when the field exceeds i.
module adc_pin_map #(
    parameter int NCH   = 4,
    parameter int CFG_W = 3
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [NCH-1:0]   ana_en,
    output logic             pwr_en
);
    for (genvar i = 0; i < NCH; i++) begin : g_pin
        assign ana_en[i] = (cfg > CFG_W'(i));
    end

    assign pwr_en = |cfg;

endmodule

// File: rtl/adc_sar_reg.sv
`timescale 1ns/1ps
// Successive-approximation trial register, MSB first.
module adc_sar_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] resolved,
    output logic             last
);
    localparam int IDX_W = (RES_W > 2) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] next_trial;
    logic [IDX_W-1:0] idx_q;

    // Current trial word with the bit under test replaced by the decision.
    always_comb begin
        resolved        = code_q;
        resolved[idx_q] = cmp_in;
    end

    always_comb begin
        next_trial = resolved;
        if (idx_q != '0) begin
            next_trial[idx_q - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            code_q <= {1'b1, {(RES_W-1){1'b0}}};
            idx_q  <= IDX_W'(RES_W - 1);
        end else if (step) begin
            code_q <= next_trial;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign code = code_q;
    assign last = (idx_q == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int NCH   = 4,
    parameter int CFG_W = 3,
    parameter int DIV_A = 2,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32,
    localparam int CH_W = (NCH > 2) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_bit,
    input  logic             int_en,
    input  logic             irq_clr,
    input  logic [CFG_W-1:0] pin_cfg,
    input  logic [1:0]       clk_sel,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             cmp_in,
    output logic             busy,
    output logic             irq_flag,
    output logic             irq_out,
    output logic [RES_W-1:0] result,
    output logic [RES_W-1:0] dac_code,
    output logic [CH_W-1:0]  dac_chan,
    output logic [NCH-1:0]   ana_en,
    output logic             pwr_en
);
    seq_state_e       state_q, state_d;
    logic             run, tick, last;
    logic             sar_clear, sar_load, sar_step, finish;
    logic [RES_W-1:0] resolved;
    logic             busy_q, irq_q;
    logic [RES_W-1:0] result_q;
    logic [CH_W-1:0]  chan_q;

    // Next-state logic: a high start bit overrides every state.
    always_comb begin
        state_d = state_q;
        if (start_bit) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_HOLD: state_d = ST_CONV;
                ST_CONV: if (tick && last) state_d = ST_DONE;
                ST_DONE: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign run       = (state_q == ST_CONV);
    assign sar_clear = (state_d == ST_HOLD);
    assign sar_load  = (state_q == ST_HOLD) && (state_d == ST_CONV);
    assign sar_step  = run && tick;
    assign finish    = (state_q == ST_CONV) && (state_d == ST_DONE);

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b1;
            irq_q    <= 1'b0;
            result_q <= '0;
            chan_q   <= '0;
        end else begin
            if (state_d == ST_HOLD) busy_q <= 1'b1;
            else if (finish)        busy_q <= 1'b0;

            if (finish)       irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;

            if (finish)   result_q <= resolved;
            if (sar_load) chan_q   <= chan_sel;
        end
    end

    adc_clk_div #(
        .DIV_A(DIV_A),
        .DIV_B(DIV_B),
        .DIV_C(DIV_C)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (clk_sel),
        .tick (tick)
    );

    adc_sar_reg #(
        .RES_W(RES_W)
    ) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sar_clear),
        .load    (sar_load),
        .step    (sar_step),
        .cmp_in  (cmp_in),
        .code    (dac_code),
        .resolved(resolved),
        .last    (last)
    );

    adc_pin_map #(
        .NCH  (NCH),
        .CFG_W(CFG_W)
    ) u_pins (
        .cfg   (pin_cfg),
        .ana_en(ana_en),
        .pwr_en(pwr_en)
    );

    assign busy     = busy_q;
    assign irq_flag = irq_q;
    assign irq_out  = irq_q && int_en;
    assign result   = result_q;
    assign dac_chan = chan_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
    parameter int RES_W = 10,
    parameter int NCH   = 4,
    parameter int CFG_W = 3,
    parameter int CH_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_bit,
    input logic [CFG_W-1:0] pin_cfg,
    input logic             busy,
    input logic             irq_flag,
    input logic [RES_W-1:0] result,
    input logic [CH_W-1:0]  dac_chan,
    input logic [NCH-1:0]   ana_en,
    input logic             pwr_en
);
    // R2: a sampled-high start bit leaves the converter busy.
    a_r2_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |=> busy);

    // R4: the request flag only rises together with the busy flag falling.
    a_r4_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));

    // R6: field zero gives no analog pins and no power.
    a_r6_all_digital: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cfg == '0) |-> (ana_en == '0 && !pwr_en));

    // R6: field at or above the channel count makes every pin analog.
    a_r6_all_analog: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cfg >= CFG_W'(NCH)) |-> (&ana_en && pwr_en));

    // R9: the result word moves only at completion.
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    // R10: the routed channel is frozen once the start bit has been low for two edges.
    a_r10_chan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_bit && !$past(start_bit) && !$past(start_bit, 2)) |-> $stable(dac_chan));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .RES_W(RES_W),
    .NCH  (NCH),
    .CFG_W(CFG_W),
    .CH_W (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_bit(start_bit),
    .pin_cfg  (pin_cfg),
    .busy     (busy),
    .irq_flag (irq_flag),
    .result   (result),
    .dac_chan (dac_chan),
    .ana_en   (ana_en),
    .pwr_en   (pwr_en)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_bit = 1'b0;
    logic       int_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic [2:0] pin_cfg = 3'b000;
    logic [1:0] clk_sel = 2'b00;
    logic [1:0] chan_sel = 2'b00;
    logic       cmp_in;
    logic       busy, irq_flag, irq_out, pwr_en;
    logic [9:0] result, dac_code;
    logic [1:0] dac_chan;
    logic [3:0] ana_en;
    logic [9:0] vin [4];

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: 1 when the selected input is at or above the trial code.
    assign cmp_in = (vin[dac_chan] >= dac_code);

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_bit(start_bit), .int_en(int_en),
        .irq_clr(irq_clr), .pin_cfg(pin_cfg), .clk_sel(clk_sel),
        .chan_sel(chan_sel), .cmp_in(cmp_in), .busy(busy),
        .irq_flag(irq_flag), .irq_out(irq_out), .result(result),
        .dac_code(dac_code), .dac_chan(dac_chan), .ana_en(ana_en),
        .pwr_en(pwr_en)
    );

    // {pin_cfg, clk_sel, chan, value, expected ana_en, expected pwr_en}
    localparam logic [21:0] VEC [8] = '{
        {3'b000, 2'b00, 2'd0, 10'h000, 4'b0000, 1'b0},
        {3'b001, 2'b01, 2'd1, 10'h3FF, 4'b0001, 1'b1},
        {3'b010, 2'b10, 2'd2, 10'h200, 4'b0011, 1'b1},
        {3'b011, 2'b11, 2'd3, 10'h1FF, 4'b0111, 1'b1},
        {3'b100, 2'b00, 2'd3, 10'h155, 4'b1111, 1'b1},
        {3'b101, 2'b01, 2'd2, 10'h2AA, 4'b1111, 1'b1},
        {3'b110, 2'b10, 2'd1, 10'h001, 4'b1111, 1'b1},
        {3'b111, 2'b00, 2'd0, 10'h3FE, 4'b1111, 1'b1}
    };

    function automatic int ratio_of(input logic [1:0] cs);
        return (cs == 2'b00) ? 2 : (cs == 2'b01) ? 8 : 32;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Called at a negedge with start high; releases it and counts edges after
    // the release-sampling edge until busy reads 0. Returns 1 ns after that edge.
    task automatic release_wait(output int k);
        start_bit = 1'b0;
        @(posedge clk);
        k = 0;
        while (k < 2000) begin
            @(posedge clk);
            k++;
            #1;
            if (!busy) break;
        end
    endtask

    task automatic set_inputs(input logic [9:0] val, input logic [1:0] ch);
        for (int i = 0; i < 4; i++) vin[i] = val ^ 10'(i * 97 + 13);
        vin[ch] = val;
    endtask

    task automatic pulse_clear();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int k;
        logic [9:0] prev;
        for (int i = 0; i < 4; i++) vin[i] = 10'd0;
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 busy", busy, 1);
        chk("R11 irq_flag", irq_flag, 0);
        chk("R11 result", result, 0);
        chk("R11 dac_code", dac_code, 0);
        chk("R11 dac_chan", dac_chan, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: start never raised, nothing happens
        set_inputs(10'h123, 2'd0);
        repeat (50) @(negedge clk);
        chk("R1 idle busy", busy, 1);
        chk("R1 idle irq", irq_flag, 0);
        chk("R1 idle dac_code", dac_code, 0);
        chk("R1 idle result", result, 0);

        // Vector table walk: R3, R6, R7, R8
        foreach (VEC[n]) begin
            @(negedge clk);
            pin_cfg = VEC[n][21:19];
            clk_sel = VEC[n][18:17];
            chan_sel = VEC[n][16:15];
            set_inputs(VEC[n][14:5], VEC[n][16:15]);
            #1;
            chk("R6 ana_en", ana_en, VEC[n][4:1]);
            chk("R6 pwr_en", pwr_en, VEC[n][0]);
            @(negedge clk); start_bit = 1'b1;
            @(negedge clk);
            chk("R2 busy during hold", busy, 1);
            release_wait(k);
            chk("R3 R7 conversion length", k, 10 * ratio_of(VEC[n][18:17]));
            chk("R8 result", result, VEC[n][14:5]);
            chk("R4 irq set at completion", irq_flag, 1);
            chk("R10 dac_chan", dac_chan, VEC[n][16:15]);
            pulse_clear();
            chk("R4 irq cleared", irq_flag, 0);
        end

        // R1: after completion, start low keeps everything still
        prev = result;
        repeat (40) @(negedge clk);
        chk("R1 busy stays low", busy, 0);
        chk("R1 no new irq", irq_flag, 0);
        chk("R1 result unchanged", result, prev);

        // R5: interrupt gating
        pin_cfg = 3'b100; clk_sel = 2'b00; chan_sel = 2'd1;
        set_inputs(10'h0F0, 2'd1);
        int_en = 1'b0;
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk);
        release_wait(k);
        chk("R5 irq_out masked", irq_out, 0);
        @(negedge clk); int_en = 1'b1; #1;
        chk("R5 irq_out enabled", irq_out, 1);
        pulse_clear(); #1;
        chk("R5 irq_out after clear", irq_out, 0);

        // R2: hold and abort in the middle of a conversion
        prev = result;
        clk_sel = 2'b01; chan_sel = 2'd2;
        set_inputs(10'h2C3, 2'd2);
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk); start_bit = 1'b0;
        repeat (30) @(negedge clk);
        chk("R2 converting busy", busy, 1);
        start_bit = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 abort dac_code", dac_code, 0);
        chk("R2 abort busy", busy, 1);
        repeat (20) @(negedge clk);
        chk("R2 held dac_code", dac_code, 0);
        chk("R2 abort no irq", irq_flag, 0);
        chk("R9 result kept on abort", result, prev);
        release_wait(k);
        chk("R3 restart length", k, 80);
        chk("R8 restart result", result, 10'h2C3);
        pulse_clear();

        // R7 R10: selects changed during a conversion are ignored
        clk_sel = 2'b01; chan_sel = 2'd3;
        set_inputs(10'h0A5, 2'd3);
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk); start_bit = 1'b0;
        @(posedge clk);
        k = 0;
        while (k < 2000) begin
            @(posedge clk);
            k++;
            #1;
            if (k == 5) begin clk_sel = 2'b00; chan_sel = 2'd0; end
            if (!busy) break;
        end
        chk("R7 ratio frozen", k, 80);
        chk("R10 channel frozen", result, 10'h0A5);
        chk("R10 dac_chan frozen", dac_chan, 3);
        pulse_clear();

        // R4: clear and completion on the same edge, set wins
        @(negedge clk);
        clk_sel = 2'b00; chan_sel = 2'd0; irq_clr = 1'b1;
        set_inputs(10'h3C0, 2'd0);
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk);
        release_wait(k);
        chk("R4 set beats clear", irq_flag, 1);
        @(posedge clk); #1;
        chk("R4 clear next edge", irq_flag, 0);
        @(negedge clk); irq_clr = 1'b0;
        chk("R8 result with clear held", result, 10'h3C0);

        summary();
    end

endmodule